// File: doc/BRIEF.md
# Transmit Frame Statistics Counters

This block keeps three transmit statistics for an Ethernet MAC. The first counts every frame sent successfully. The second counts successful frames that needed exactly one collision. The third counts successful frames that needed two or more collisions. The two collision counters only advance in half-duplex operation. The MAC's transmit side reports each finished frame with a one-cycle done strobe. A good flag and the number of collisions the frame met come with it. A level input gives the duplex mode.

Each counter has a sticky interrupt status bit. The bit is set on the increment that turns the counter's top bit on, which is half of its full range. Reading the counter clears the bit. A mask register holds one mask bit per counter. The interrupt output is high while any status bit is pending and its mask bit is clear.

Software reaches the mask and the counters through a simple register port. A read strobe returns data on the following cycle. A counter-reset input clears all counters and status bits in one cycle and leaves the mask as it is.

Top module: `txStatCounters`

## Requirements
- R1: After reset, all counters, the mask register and all status bits are zero, and `irq` is low.
- R2: The good-frame counter (read at offset 0x04) increments by one for each `frmDone` with `frmGood` high, whatever the collision count or duplex mode. Frames with `frmGood` low are not counted.
- R3: The single-collision counter (offset 0x08) increments only for a good frame with `collCnt` equal to 1 while `halfDuplex` is high.
- R4: The multiple-collision counter (offset 0x0C) increments only for a good frame with `collCnt` of 2 or more while `halfDuplex` is high.
- R5: With `halfDuplex` low, neither collision counter changes, whatever the value of `collCnt`.
- R6: A counter's status bit is set by the increment that changes its top bit from 0 to 1, and it stays set until it is cleared. `irq` is the OR of all status bits whose mask bit is clear.
- R7: The mask register is at offset 0x00. Bit 21 masks the good-frame counter, bit 15 masks the multiple-collision counter and bit 14 masks the single-collision counter. All other bits read as zero. A masked status bit stays pending and raises `irq` again once it is unmasked.
- R8: A read strobe returns the addressed register on `regRdData` one cycle later. Reading a counter clears its status bit, but an increment that reaches half scale in the same cycle leaves the bit set. Unmapped offsets read zero.
- R9: Counters wrap from all ones to zero and do not saturate. A wrap does not clear a pending status bit. Writes to counter offsets have no effect.
- R10: `cntClr` clears all counters and status bits in one cycle and leaves the mask unchanged. It takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cntClr | input | 1 | Synchronous clear of all counters and status bits |
| frmDone | input | 1 | One-cycle strobe marking the end of a transmitted frame |
| frmGood | input | 1 | The frame was transmitted successfully |
| collCnt | input | COLL_W | Number of collisions the frame met |
| halfDuplex | input | 1 | High while the MAC runs in half-duplex mode |
| regAddr | input | ADDR_W | Byte offset for register access |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRd | input | 1 | Register read strobe |
| regRdData | output | 32 | Read data, valid the cycle after `regRd` |
| irq | output | 1 | Interrupt: any unmasked pending status |

## Verification
Two functions can meet in one clock cycle. A read can clear a counter's status in the same cycle that an increment sets it at half scale, and a counter reset can arrive in the same cycle as a frame increment. The bench brings about the first case by driving a qualifying frame together with a read of the same counter when the counter sits one below half scale. It then checks that the read returns the old value and that `irq` stays high. It brings about the second case by pulsing `cntClr` alongside a good frame. Read-back must then show every counter at zero, the mask unchanged and no pending interrupt after unmasking.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
  localparam int NCNT = 3;
  localparam int DATA_W = 32;

  localparam int IDX_GOOD   = 0;
  localparam int IDX_SINGLE = 1;
  localparam int IDX_MULTI  = 2;

  localparam int OFS_MASK   = 'h00;
  localparam int OFS_GOOD   = 'h04;
  localparam int OFS_SINGLE = 'h08;
  localparam int OFS_MULTI  = 'h0C;

  localparam int MB_GOOD   = 21;
  localparam int MB_MULTI  = 15;
  localparam int MB_SINGLE = 14;

  localparam logic [DATA_W-1:0] MASK_VALID =
    (DATA_W'(1) << MB_GOOD) | (DATA_W'(1) << MB_MULTI) | (DATA_W'(1) << MB_SINGLE);

  typedef enum logic [1:0] {
    SEL_MASK   = 2'd0,
    SEL_GOOD   = 2'd1,
    SEL_SINGLE = 2'd2,
    SEL_MULTI  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic [NCNT-1:0] inc;
    logic [NCNT-1:0] rdClr;
    logic            maskWe;
    logic            rdEn;
    logic            rdHit;
    rdSel_e          rdSel;
    logic            clrAll;
  } ctrlStrobes_t;

  function automatic int maskBitOf(input int idx);
    case (idx)
      IDX_GOOD:   return MB_GOOD;
      IDX_SINGLE: return MB_SINGLE;
      default:    return MB_MULTI;
    endcase
  endfunction
endpackage

// File: rtl/txstat_ctrl.sv
module txstat_ctrl
  import txstat_pkg::*;
#(
  parameter int COLL_W = 5,
  parameter int ADDR_W = 8
) (
  input  logic              cntClr,
  input  logic              frmDone,
  input  logic              frmGood,
  input  logic [COLL_W-1:0] collCnt,
  input  logic              halfDuplex,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  output ctrlStrobes_t      strb
);
  logic goodFrm;
  logic oneColl;
  logic manyColl;
  logic hitMask, hitGood, hitSingle, hitMulti;

  assign goodFrm  = frmDone & frmGood;
  assign oneColl  = (collCnt == COLL_W'(1));
  assign manyColl = (collCnt >= COLL_W'(2));

  assign hitMask   = (regAddr == ADDR_W'(OFS_MASK));
  assign hitGood   = (regAddr == ADDR_W'(OFS_GOOD));
  assign hitSingle = (regAddr == ADDR_W'(OFS_SINGLE));
  assign hitMulti  = (regAddr == ADDR_W'(OFS_MULTI));

  always_comb begin
    strb = '0;
    strb.clrAll = cntClr;

    strb.inc[IDX_GOOD]   = goodFrm;
    strb.inc[IDX_SINGLE] = goodFrm & halfDuplex & oneColl;
    strb.inc[IDX_MULTI]  = goodFrm & halfDuplex & manyColl;

    strb.maskWe = regWr & hitMask;

    strb.rdEn  = regRd;
    strb.rdHit = hitMask | hitGood | hitSingle | hitMulti;
    if (hitGood)        strb.rdSel = SEL_GOOD;
    else if (hitSingle) strb.rdSel = SEL_SINGLE;
    else if (hitMulti)  strb.rdSel = SEL_MULTI;
    else                strb.rdSel = SEL_MASK;

    strb.rdClr[IDX_GOOD]   = regRd & hitGood;
    strb.rdClr[IDX_SINGLE] = regRd & hitSingle;
    strb.rdClr[IDX_MULTI]  = regRd & hitMulti;
  end
endmodule

// File: rtl/txstat_datapath.sv
module txstat_datapath
  import txstat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strb,
  input  logic [DATA_W-1:0]      regWrData,
  output logic [DATA_W-1:0]      regRdData,
  output logic [NCNT*CNT_W-1:0]  cntFlat,
  output logic [NCNT-1:0]        stsVec,
  output logic                   irq
);
  localparam logic [CNT_W-1:0] HALF_M1 = {1'b0, {(CNT_W-1){1'b1}}};

  logic [DATA_W-1:0] maskQ;
  logic [CNT_W-1:0]  cntQ [NCNT];
  logic [NCNT-1:0]   rise;
  logic [NCNT-1:0]   maskEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskQ <= '0;
    else if (strb.maskWe) maskQ <= regWrData & MASK_VALID;
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    localparam int MB = maskBitOf(i);

    assign rise[i]   = strb.inc[i] & (cntQ[i] == HALF_M1);
    assign maskEn[i] = maskQ[MB];
    assign cntFlat[i*CNT_W +: CNT_W] = cntQ[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              cntQ[i] <= '0;
      else if (strb.clrAll)   cntQ[i] <= '0;
      else if (strb.inc[i])   cntQ[i] <= cntQ[i] + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               stsVec[i] <= 1'b0;
      else if (strb.clrAll)    stsVec[i] <= 1'b0;
      else if (rise[i])        stsVec[i] <= 1'b1;
      else if (strb.rdClr[i])  stsVec[i] <= 1'b0;
    end
  end

  assign irq = |(stsVec & ~maskEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdData <= '0;
    else if (strb.rdEn) begin
      if (!strb.rdHit) regRdData <= '0;
      else begin
        case (strb.rdSel)
          SEL_GOOD:   regRdData <= DATA_W'(cntQ[IDX_GOOD]);
          SEL_SINGLE: regRdData <= DATA_W'(cntQ[IDX_SINGLE]);
          SEL_MULTI:  regRdData <= DATA_W'(cntQ[IDX_MULTI]);
          default:    regRdData <= maskQ;
        endcase
      end
    end
  end
endmodule

// File: rtl/txStatCounters.sv
module txStatCounters
  import txstat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int COLL_W = 5,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntClr,
  input  logic              frmDone,
  input  logic              frmGood,
  input  logic [COLL_W-1:0] collCnt,
  input  logic              halfDuplex,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWrData,
  input  logic              regRd,
  output logic [31:0]       regRdData,
  output logic              irq
);
  ctrlStrobes_t            strb;
  logic [NCNT*CNT_W-1:0]   cntFlat;
  logic [NCNT-1:0]         stsVec;

  txstat_ctrl #(.COLL_W(COLL_W), .ADDR_W(ADDR_W)) u_ctrl (
    .cntClr(cntClr), .frmDone(frmDone), .frmGood(frmGood), .collCnt(collCnt),
    .halfDuplex(halfDuplex), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .strb(strb)
  );

  txstat_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .regRdData(regRdData), .cntFlat(cntFlat), .stsVec(stsVec), .irq(irq)
  );
endmodule

// File: rtl/txstat_chk.sv
module txstat_chk
  import txstat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int COLL_W = 5,
  parameter int ADDR_W = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  cntClr,
  input logic                  frmDone,
  input logic                  frmGood,
  input logic [COLL_W-1:0]     collCnt,
  input logic                  halfDuplex,
  input logic [ADDR_W-1:0]     regAddr,
  input logic                  regRd,
  input logic [31:0]           regRdData,
  input logic                  irq,
  input logic [NCNT*CNT_W-1:0] cntFlat,
  input logic [NCNT-1:0]       stsVec
);
  logic [CNT_W-1:0] goodCnt, singleCnt, multiCnt;
  assign goodCnt   = cntFlat[IDX_GOOD*CNT_W   +: CNT_W];
  assign singleCnt = cntFlat[IDX_SINGLE*CNT_W +: CNT_W];
  assign multiCnt  = cntFlat[IDX_MULTI*CNT_W  +: CNT_W];

  AST_GOOD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    frmDone && frmGood && !cntClr |=> goodCnt == CNT_W'($past(goodCnt) + 1)); // R2

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    frmDone && frmGood && halfDuplex && collCnt == COLL_W'(1) && !cntClr
      |=> singleCnt == CNT_W'($past(singleCnt) + 1)); // R3

  AST_MULTI_STEP: assert property (@(posedge clk) disable iff (!rstN)
    frmDone && frmGood && halfDuplex && collCnt >= COLL_W'(2) && !cntClr
      |=> multiCnt == CNT_W'($past(multiCnt) + 1)); // R4

  AST_FULLDUP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !halfDuplex && !cntClr |=> $stable(singleCnt) && $stable(multiCnt)); // R5

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> stsVec != '0); // R6

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    stsVec[IDX_GOOD] && !cntClr && !(regRd && regAddr == ADDR_W'(OFS_GOOD))
      |=> stsVec[IDX_GOOD]); // R6

  AST_MASK_RSVD: assert property (@(posedge clk) disable iff (!rstN)
    regRd && regAddr == ADDR_W'(OFS_MASK) |=> (regRdData & ~MASK_VALID) == '0); // R7

  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    cntClr |=> cntFlat == '0 && stsVec == '0 && !irq); // R10
endmodule

bind txStatCounters txstat_chk #(.CNT_W(CNT_W), .COLL_W(COLL_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_txStatCounters.sv
`timescale 1ns/1ps
module sim_txStatCounters;
  localparam int CW = 8;
  localparam int HALF = 1 << (CW - 1);
  localparam int FULL = 1 << CW;
  localparam logic [31:0] VALID = 32'h0020_C000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntClr = 0, frmDone = 0, frmGood = 0, halfDuplex = 0;
  logic [4:0] collCnt = '0;
  logic [7:0] regAddr = '0;
  logic regWr = 0, regRd = 0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic irq;

  always #5 clk = ~clk;

  txStatCounters #(.CNT_W(CW), .COLL_W(5), .ADDR_W(8)) u0 (
    .clk(clk), .rstN(rstN), .cntClr(cntClr), .frmDone(frmDone), .frmGood(frmGood),
    .collCnt(collCnt), .halfDuplex(halfDuplex), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRd(regRd), .regRdData(regRdData), .irq(irq)
  );

  int nCmp = 0, nBad = 0;
  bit done = 0;
  int mCnt [3] = '{0, 0, 0};
  bit mSts [3] = '{0, 0, 0};
  logic [31:0] mMask = '0;
  logic [31:0] expQ [$];
  string tagQ [$];
  logic rdSeen = 0;

  always @(posedge clk) rdSeen <= regRd;

  always @(negedge clk) begin
    if (rdSeen) begin
      nCmp++;
      if (expQ.size() == 0) begin
        nBad++;
        $display("FAIL read with no expected item: actual %h expected none", regRdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (regRdData !== e) begin
          nBad++;
          $display("FAIL %s: regRdData actual %h expected %h", t, regRdData, e);
        end
      end
    end
  end

  task automatic cycleDo(input bit fr, input bit good, input int coll, input bit hd,
                         input bit rd, input bit wr, input logic [7:0] addr,
                         input logic [31:0] wdata, input bit clr, input string tag);
    bit inc [3];
    int ridx;
    @(negedge clk);
    frmDone = fr; frmGood = good; collCnt = 5'(coll); halfDuplex = hd;
    regRd = rd; regWr = wr; regAddr = addr; regWrData = wdata; cntClr = clr;
    if (rd) begin
      logic [31:0] e;
      case (addr)
        8'h00:   e = mMask;
        8'h04:   e = 32'(mCnt[0]);
        8'h08:   e = 32'(mCnt[1]);
        8'h0C:   e = 32'(mCnt[2]);
        default: e = '0;
      endcase
      expQ.push_back(e);
      tagQ.push_back(tag);
    end
    inc[0] = fr && good;
    inc[1] = fr && good && hd && coll == 1;
    inc[2] = fr && good && hd && coll >= 2;
    ridx = !rd ? -1 : (addr == 8'h04) ? 0 : (addr == 8'h08) ? 1 : (addr == 8'h0C) ? 2 : -1;
    if (clr) begin
      for (int i = 0; i < 3; i++) begin mCnt[i] = 0; mSts[i] = 0; end
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (ridx == i) mSts[i] = 0;
        if (inc[i]) begin
          if (mCnt[i] == HALF - 1) mSts[i] = 1;
          mCnt[i] = (mCnt[i] + 1) % FULL;
        end
      end
    end
    if (wr && addr == 8'h00) mMask = wdata & VALID;
    @(negedge clk);
    frmDone = 0; frmGood = 0; collCnt = '0; regRd = 0; regWr = 0; cntClr = 0;
  endtask

  task automatic frame(input bit good, input int coll, input bit hd);
    cycleDo(1, good, coll, hd, 0, 0, 8'h00, '0, 0, "");
  endtask

  task automatic rd(input logic [7:0] addr, input string tag);
    cycleDo(0, 0, 0, 0, 1, 0, addr, '0, 0, tag);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] d);
    cycleDo(0, 0, 0, 0, 0, 1, addr, d, 0, "");
  endtask

  task automatic chkIrq(input string tag);
    bit e;
    bit m [3];
    m[0] = mMask[21]; m[1] = mMask[14]; m[2] = mMask[15];
    e = 0;
    for (int i = 0; i < 3; i++) if (mSts[i] && !m[i]) e = 1;
    @(negedge clk);
    nCmp++;
    if (irq !== e) begin
      nBad++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq, e);
    end
  endtask

  task automatic rdAll(input string tag);
    rd(8'h00, tag); rd(8'h04, tag); rd(8'h08, tag); rd(8'h0C, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chkIrq("R1 irq after reset");
    rdAll("R1 reset value");
    rd(8'h20, "R8 unmapped offset reads zero");

    // R2 / R5: full duplex, various collision counts, plus a bad frame
    frame(1, 0, 0); frame(1, 1, 0); frame(1, 3, 0); frame(0, 1, 0);
    rdAll("R2 R5 full duplex counting");

    // R3 / R4: half duplex collision classes, bad frames ignored
    frame(1, 1, 1); frame(1, 1, 1); frame(1, 2, 1); frame(1, 15, 1);
    frame(1, 0, 1); frame(0, 1, 1); frame(0, 4, 1);
    rdAll("R3 R4 half duplex counting");

    // R7: mask reserved bits; R9: counter writes ignored
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, "R7 mask readback");
    wr(8'h04, 32'h0000_0055);
    wr(8'h08, 32'h0000_00AA);
    rd(8'h04, "R9 write to good counter ignored");
    rd(8'h08, "R9 write to single counter ignored");
    wr(8'h00, 32'h0);

    // R6: half-scale crossing on the good counter
    while (mCnt[0] < HALF - 1) frame(1, 0, 0);
    chkIrq("R6 no irq one below half scale");
    frame(1, 0, 0);
    chkIrq("R6 irq at half scale");

    // R7: masking holds the status pending
    wr(8'h00, 32'h0020_0000);
    chkIrq("R7 masked irq low");
    wr(8'h00, 32'h0);
    chkIrq("R7 unmasked pending irq returns");

    // R9: wrap keeps pending status
    while (mCnt[0] != 0) frame(1, 0, 0);
    chkIrq("R9 irq still pending after wrap");
    rd(8'h04, "R9 counter wrapped to zero");
    chkIrq("R8 read clears status");

    // R8: set and read-clear in the same cycle on the single-collision counter
    while (mCnt[1] < HALF - 1) frame(1, 1, 1);
    cycleDo(1, 1, 1, 1, 1, 0, 8'h08, '0, 0, "R8 read during half-scale step");
    chkIrq("R8 set wins over read clear");
    rd(8'h08, "R8 value after half-scale step");
    chkIrq("R8 status cleared by later read");

    // R10: clear with a frame in the same cycle, mask preserved
    wr(8'h00, 32'h0000_8000);
    while (mCnt[2] < HALF) frame(1, 2, 1);
    chkIrq("R7 multi status masked");
    cycleDo(1, 1, 3, 1, 0, 0, 8'h00, '0, 1, "");
    rdAll("R10 clear beats increment");
    wr(8'h00, 32'h0);
    chkIrq("R10 status cleared by counter reset");

    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule